// File: doc/BRIEF.md
# NAND Page Hamming ECC Checker and Bit Corrector

This block takes, for every 256-byte chunk of a NAND page, two 24-bit Hamming codes: the one read back from the spare area and the one computed over the data just read. It compares them, sorts the result into one of four classes, and for a single flipped data bit gives the page byte offset and the bit index of that bit. A page holds one chunk (256 bytes) or two chunks (512 bytes). The page mode is chosen per request, and each chunk uses its own pair of codes.

A request is a one-cycle start strobe with the codes on the inputs. The verdict is registered on the clock edge that samples start, and a one-cycle done pulse marks it. When the caller also asks for repair, a small sequencer patches the page buffer through a byte-wide port. For each chunk that has a correctable error, chunk 0 first, it reads the byte and then writes it back with the bad bit inverted. A fix-done pulse ends each request.

Top module: `nand_ecc_corrector`

## Requirements
- R1: After reset, done, fix_done, mem_rd and mem_wr are 0, status and every chunk status are 0, and every error offset and bit index is 0.
- R2: A start that is accepted, on a cycle when no earlier request is in progress, makes done equal 1 for exactly the next cycle. The status and location outputs change on that same edge and then hold until the next accepted start.
- R3: A chunk is clean (status code 0, location 0) when the XOR syndrome of its stored and calculated codes is zero, or when either code is all zero.
- R4: A syndrome with exactly one bit set gives status code 2 (the check field itself is corrupt). The location is 0 and no repair write is made.
- R5: A syndrome with exactly 11 bits set, whose bits 10:0 XOR bits 21:11 equal 0x7FF, gives status code 1 (correctable). The bit index is syndrome bits 2:0. The page byte offset is the chunk number times 256 plus syndrome bits 10:3.
- R6: Every other nonzero syndrome, when both codes are nonzero, gives status code 3 (uncorrectable).
- R7: In two-chunk mode (wide_page = 1), chunk 1 is classified from bits 47:24 of the code inputs. In one-chunk mode, the chunk 1 status and location are 0 whatever codes are on those bits.
- R8: The page status equals the largest chunk status code, so the order of severity is 0 < 1 < 2 < 3.
- R9: When fix_req was 1 at the accepted start, each correctable chunk is repaired, in ascending chunk order. A one-cycle mem_rd at the byte offset is followed on the next cycle by a one-cycle mem_wr at the same offset. The write data is the byte returned on mem_rdata with the located bit inverted. A read issued in one cycle returns its data in the next. Without fix_req, no memory access takes place.
- R10: fix_done pulses for one cycle 2 + 2·k cycles after the start edge, where k is the number of chunks repaired. A start that arrives while done is high or a repair is in progress is ignored: no done pulse follows and the outputs are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe |
| wide_page | input | 1 | 1: two chunks (512-byte page); 0: chunk 0 only |
| fix_req | input | 1 | Request in-buffer repair of correctable bits |
| stored_codes | input | 48 | Codes read from flash, chunk c at bits 24c+23:24c |
| calc_codes | input | 48 | Codes computed over the data, same layout |
| done | output | 1 | Verdict valid pulse |
| status | output | 2 | Page verdict, worst chunk code |
| chunk_status | output | 4 | Per-chunk verdict, chunk c at bits 2c+1:2c |
| err_offset | output | 18 | Page byte offset of the bad bit, chunk c at bits 9c+8:9c |
| err_bit | output | 6 | Bit index of the bad bit, chunk c at bits 3c+2:3c |
| mem_rd | output | 1 | Buffer read strobe |
| mem_wr | output | 1 | Buffer write strobe |
| mem_addr | output | 9 | Buffer byte address |
| mem_wdata | output | 8 | Buffer write data |
| mem_rdata | input | 8 | Buffer read data, valid the cycle after mem_rd |
| fix_done | output | 1 | End-of-request pulse |

## Verification
If the syndrome classification goes wrong, the status and location show it in the first cycle of done, one edge after start. So the sweep over every byte and bit position of a chunk exposes a wrong bit-to-offset mapping straight away. A corrupt repair index or a bad pending mask shows as a wrong address or wrong write data on the buffer port within two cycles. It also shows as a fix-done pulse that comes too early or too late, and the count of cycles to fix-done shows this. A broken busy guard lets a second done pulse through during repair, and this can be seen in the cycle after the ignored start.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
   typedef enum logic [1:0] {
      ST_CLEAN  = 2'd0,
      ST_FIXED  = 2'd1,
      ST_ECCFLD = 2'd2,
      ST_BAD    = 2'd3
   } ecc_status_e;
endpackage

// File: rtl/ecc_popcount.sv
module ecc_popcount #(
   parameter int W  = 24,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] ones
);
   if (W < 1) begin : g_bad_w
      $error("ecc_popcount: W must be positive");
   end

   always_comb begin
      ones = '0;
      for (int i = 0; i < W; i++) begin
         ones = ones + CW'(vec[i]);
      end
   end
endmodule

// File: rtl/ecc_chunk_classify.sv
module ecc_chunk_classify
   import nand_ecc_pkg::*;
#(
   parameter int CODE_W = 24,
   parameter int HALF_W = 11
) (
   input  logic [CODE_W-1:0] stored_code,
   input  logic [CODE_W-1:0] calc_code,
   output ecc_status_e       status,
   output logic [HALF_W-4:0] loc_byte,
   output logic [2:0]        loc_bit
);
   localparam int CNT_W = $clog2(CODE_W + 1);

   if (CODE_W < 2 * HALF_W) begin : g_bad_code
      $error("ecc_chunk_classify: CODE_W must hold both halves");
   end
   if (HALF_W < 4) begin : g_bad_half
      $error("ecc_chunk_classify: HALF_W too small for a byte offset");
   end

   logic [CODE_W-1:0] syndrome;
   logic [CNT_W-1:0]  ones;
   logic [HALF_W-1:0] pair_mix;

   assign syndrome = stored_code ^ calc_code;
   assign pair_mix = syndrome[HALF_W-1:0] ^ syndrome[2*HALF_W-1:HALF_W];

   ecc_popcount #(.W(CODE_W), .CW(CNT_W)) u_pop (
      .vec  (syndrome),
      .ones (ones)
   );

   always_comb begin
      status   = ST_BAD;
      loc_byte = '0;
      loc_bit  = '0;
      if (syndrome == '0 || stored_code == '0 || calc_code == '0) begin
         status = ST_CLEAN;
      end else if (ones == CNT_W'(1)) begin
         status = ST_ECCFLD;
      end else if (ones == CNT_W'(HALF_W) && pair_mix == '1) begin
         status   = ST_FIXED;
         loc_byte = syndrome[HALF_W-1:3];
         loc_bit  = syndrome[2:0];
      end
   end
endmodule

// File: rtl/ecc_bit_fixer.sv
module ecc_bit_fixer #(
   parameter int NCHUNK = 2,
   parameter int OFS_W  = 9,
   parameter int IDX_W  = (NCHUNK > 1) ? $clog2(NCHUNK) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    launch,
   input  logic [NCHUNK-1:0]       fix_mask,
   input  logic [NCHUNK*OFS_W-1:0] offsets,
   input  logic [NCHUNK*3-1:0]     bits,
   input  logic [7:0]              mem_rdata,
   output logic                    mem_rd,
   output logic                    mem_wr,
   output logic [OFS_W-1:0]        mem_addr,
   output logic [7:0]              mem_wdata,
   output logic                    busy,
   output logic                    fix_done
);
   typedef enum logic [1:0] {FX_IDLE, FX_READ, FX_WRITE} fix_state_e;

   fix_state_e        state;
   logic [NCHUNK-1:0] pending;
   logic [NCHUNK-1:0] pending_next;
   logic [IDX_W-1:0]  cur;

   function automatic logic [IDX_W-1:0] lowest(input logic [NCHUNK-1:0] m);
      logic [IDX_W-1:0] r;
      r = '0;
      for (int i = NCHUNK - 1; i >= 0; i--) begin
         if (m[i]) r = IDX_W'(i);
      end
      return r;
   endfunction

   assign pending_next = pending & ~(NCHUNK'(1) << cur);
   assign mem_rd    = (state == FX_READ);
   assign mem_wr    = (state == FX_WRITE);
   assign mem_addr  = (state == FX_IDLE) ? '0 : offsets[cur*OFS_W +: OFS_W];
   assign mem_wdata = (state == FX_WRITE) ?
                      (mem_rdata ^ (8'd1 << bits[cur*3 +: 3])) : 8'd0;
   assign busy      = (state != FX_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= FX_IDLE;
         pending  <= '0;
         cur      <= '0;
         fix_done <= 1'b0;
      end else begin
         fix_done <= 1'b0;
         case (state)
            FX_IDLE: begin
               if (launch) begin
                  pending <= fix_mask;
                  cur     <= lowest(fix_mask);
                  if (fix_mask == '0) fix_done <= 1'b1;
                  else                state    <= FX_READ;
               end
            end
            FX_READ: state <= FX_WRITE;
            FX_WRITE: begin
               pending <= pending_next;
               cur     <= lowest(pending_next);
               if (pending_next == '0) begin
                  state    <= FX_IDLE;
                  fix_done <= 1'b1;
               end else begin
                  state <= FX_READ;
               end
            end
            default: state <= FX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/nand_ecc_corrector.sv
module nand_ecc_corrector
   import nand_ecc_pkg::*;
#(
   parameter int MAX_CHUNKS = 2,
   parameter int CODE_W     = 24,
   parameter int HALF_W     = 11,
   parameter bit FIX_EN     = 1'b1,
   parameter int BYTE_W     = HALF_W - 3,
   parameter int OFS_W      = BYTE_W + ((MAX_CHUNKS > 1) ? $clog2(MAX_CHUNKS) : 0)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic                         wide_page,
   input  logic                         fix_req,
   input  logic [MAX_CHUNKS*CODE_W-1:0] stored_codes,
   input  logic [MAX_CHUNKS*CODE_W-1:0] calc_codes,
   output logic                         done,
   output logic [1:0]                   status,
   output logic [MAX_CHUNKS*2-1:0]      chunk_status,
   output logic [MAX_CHUNKS*OFS_W-1:0]  err_offset,
   output logic [MAX_CHUNKS*3-1:0]      err_bit,
   output logic                         mem_rd,
   output logic                         mem_wr,
   output logic [OFS_W-1:0]             mem_addr,
   output logic [7:0]                   mem_wdata,
   input  logic [7:0]                   mem_rdata,
   output logic                         fix_done
);
   localparam int CHUNK_BYTES = 1 << BYTE_W;

   if (MAX_CHUNKS < 1 || MAX_CHUNKS > 2) begin : g_bad_chunks
      $error("nand_ecc_corrector: MAX_CHUNKS must be 1 or 2");
   end

   ecc_status_e             cls_st  [MAX_CHUNKS];
   logic [BYTE_W-1:0]       cls_byte[MAX_CHUNKS];
   logic [2:0]              cls_bit [MAX_CHUNKS];
   ecc_status_e             st_q    [MAX_CHUNKS];
   logic [OFS_W-1:0]        off_q   [MAX_CHUNKS];
   logic [2:0]              bit_q   [MAX_CHUNKS];
   logic [MAX_CHUNKS-1:0]   fix_mask;
   logic                    fix_req_q;
   logic                    done_q;
   logic                    fixer_busy;
   logic                    accept;

   assign accept = start & ~done_q & ~fixer_busy;
   assign done   = done_q;

   for (genvar c = 0; c < MAX_CHUNKS; c++) begin : g_chunk
      logic active;
      assign active = (c == 0) || wide_page;

      ecc_chunk_classify #(.CODE_W(CODE_W), .HALF_W(HALF_W)) u_cls (
         .stored_code (stored_codes[c*CODE_W +: CODE_W]),
         .calc_code   (calc_codes[c*CODE_W +: CODE_W]),
         .status      (cls_st[c]),
         .loc_byte    (cls_byte[c]),
         .loc_bit     (cls_bit[c])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q[c]  <= ST_CLEAN;
            off_q[c] <= '0;
            bit_q[c] <= '0;
         end else if (accept) begin
            if (active) begin
               st_q[c]  <= cls_st[c];
               off_q[c] <= (cls_st[c] == ST_FIXED) ?
                           OFS_W'(c * CHUNK_BYTES) + OFS_W'(cls_byte[c]) : '0;
               bit_q[c] <= cls_bit[c];
            end else begin
               st_q[c]  <= ST_CLEAN;
               off_q[c] <= '0;
               bit_q[c] <= '0;
            end
         end
      end

      assign chunk_status[c*2 +: 2]     = st_q[c];
      assign err_offset[c*OFS_W +: OFS_W] = off_q[c];
      assign err_bit[c*3 +: 3]          = bit_q[c];
      assign fix_mask[c]                = fix_req_q && (st_q[c] == ST_FIXED);
   end

   always_comb begin
      status = 2'd0;
      for (int c = 0; c < MAX_CHUNKS; c++) begin
         if (2'(st_q[c]) > status) status = 2'(st_q[c]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q    <= 1'b0;
         fix_req_q <= 1'b0;
      end else begin
         done_q <= accept;
         if (accept) fix_req_q <= fix_req;
      end
   end

   if (FIX_EN) begin : g_fixer
      ecc_bit_fixer #(.NCHUNK(MAX_CHUNKS), .OFS_W(OFS_W)) u_fix (
         .clk       (clk),
         .rst_n     (rst_n),
         .launch    (done_q),
         .fix_mask  (fix_mask),
         .offsets   (err_offset),
         .bits      (err_bit),
         .mem_rdata (mem_rdata),
         .mem_rd    (mem_rd),
         .mem_wr    (mem_wr),
         .mem_addr  (mem_addr),
         .mem_wdata (mem_wdata),
         .busy      (fixer_busy),
         .fix_done  (fix_done)
      );
   end else begin : g_no_fixer
      assign mem_rd     = 1'b0;
      assign mem_wr     = 1'b0;
      assign mem_addr   = '0;
      assign mem_wdata  = '0;
      assign fixer_busy = 1'b0;
      assign fix_done   = 1'b0;
   end
endmodule

// File: rtl/nand_ecc_corrector_chk.sv
module nand_ecc_corrector_chk #(
   parameter int MAX_CHUNKS = 2,
   parameter int OFS_W      = 9
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        start,
   input logic                        done,
   input logic [1:0]                  status,
   input logic [MAX_CHUNKS*2-1:0]     chunk_status,
   input logic [MAX_CHUNKS*OFS_W-1:0] err_offset,
   input logic [MAX_CHUNKS*3-1:0]     err_bit,
   input logic                        mem_rd,
   input logic                        mem_wr,
   input logic [OFS_W-1:0]            mem_addr,
   input logic                        fix_done
);
   p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(start));
   p_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(status) && $stable(err_offset) && $stable(err_bit)));

   for (genvar c = 0; c < MAX_CHUNKS; c++) begin : g_chk
      p_loc_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (chunk_status[c*2 +: 2] != 2'd1) |->
         (err_offset[c*OFS_W +: OFS_W] == '0 && err_bit[c*3 +: 3] == 3'd0));
      p_worst_r8: assert property (@(posedge clk) disable iff (!rst_n)
         status >= chunk_status[c*2 +: 2]);
   end

   p_rd_then_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> (mem_wr && mem_addr == $past(mem_addr)));
   p_wr_after_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> $past(mem_rd));
   p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));
   p_fixdone_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fix_done |=> !fix_done);
endmodule

bind nand_ecc_corrector nand_ecc_corrector_chk #(
   .MAX_CHUNKS (MAX_CHUNKS),
   .OFS_W      (OFS_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .done         (done),
   .status       (status),
   .chunk_status (chunk_status),
   .err_offset   (err_offset),
   .err_bit      (err_bit),
   .mem_rd       (mem_rd),
   .mem_wr       (mem_wr),
   .mem_addr     (mem_addr),
   .fix_done     (fix_done)
);

// File: tb/nand_ecc_corrector_bench.sv
`timescale 1ns/1ps
module nand_ecc_corrector_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        wide_page = 1'b0;
   logic        fix_req = 1'b0;
   logic [47:0] stored_codes = '0;
   logic [47:0] calc_codes = '0;
   logic        done;
   logic [1:0]  status;
   logic [3:0]  chunk_status;
   logic [17:0] err_offset;
   logic [5:0]  err_bit;
   logic        mem_rd, mem_wr;
   logic [8:0]  mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;
   logic        fix_done;

   int checks = 0;
   int errors = 0;
   logic [7:0] mem [512];

   always #4 clk = ~clk;

   nand_ecc_corrector u_nand_ecc_corrector (
      .clk(clk), .rst_n(rst_n), .start(start), .wide_page(wide_page),
      .fix_req(fix_req), .stored_codes(stored_codes), .calc_codes(calc_codes),
      .done(done), .status(status), .chunk_status(chunk_status),
      .err_offset(err_offset), .err_bit(err_bit), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .fix_done(fix_done)
   );

   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= mem[mem_addr];
      if (mem_wr) mem[mem_addr] <= mem_wdata;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // Classification model written from R3..R6
   task automatic model(input logic [23:0] s, input logic [23:0] c,
                        output logic [1:0] st, output logic [7:0] byt,
                        output logic [2:0] bt);
      logic [23:0] syn;
      syn = s ^ c;
      byt = 8'd0;
      bt  = 3'd0;
      if (syn == 0 || s == 0 || c == 0) st = 2'd0;
      else if ($countones(syn) == 1) st = 2'd2;
      else if ($countones(syn) == 11 && (syn[10:0] ^ syn[21:11]) == 11'h7FF) begin
         st = 2'd1; byt = syn[10:3]; bt = syn[2:0];
      end else st = 2'd3;
   endtask

   function automatic logic [23:0] fix_syn(input logic [10:0] p);
      return {2'b00, ~p, p};
   endfunction

   // Start a request, check done and the verdict (R2..R8), return at N2
   task automatic run(input logic [23:0] s0, input logic [23:0] c0,
                      input logic [23:0] s1, input logic [23:0] c1,
                      input bit wide, input bit fx);
      logic [1:0] e0, e1, ew;
      logic [7:0] b0, b1;
      logic [2:0] t0, t1;
      model(s0, c0, e0, b0, t0);
      model(s1, c1, e1, b1, t1);
      if (!wide) begin e1 = 0; b1 = 0; t1 = 0; end
      ew = (e0 > e1) ? e0 : e1;
      @(negedge clk);
      stored_codes = {s1, s0};
      calc_codes   = {c1, c0};
      wide_page = wide;
      fix_req   = fx;
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b1, "R2 done after start", 32'(done), 1);
      chk(chunk_status[1:0] == e0, "R3/R4/R5/R6 chunk0 status", 32'(chunk_status[1:0]), 32'(e0));
      chk(chunk_status[3:2] == e1, "R7 chunk1 status", 32'(chunk_status[3:2]), 32'(e1));
      chk(status == ew, "R8 page status", 32'(status), 32'(ew));
      chk(err_offset[8:0] == ((e0 == 1) ? {1'b0, b0} : 9'd0), "R5 chunk0 offset",
          32'(err_offset[8:0]), 32'((e0 == 1) ? {1'b0, b0} : 9'd0));
      chk(err_bit[2:0] == t0, "R5 chunk0 bit", 32'(err_bit[2:0]), 32'(t0));
      chk(err_offset[17:9] == ((e1 == 1) ? {1'b1, b1} : 9'd0), "R5 R7 chunk1 offset",
          32'(err_offset[17:9]), 32'((e1 == 1) ? {1'b1, b1} : 9'd0));
      chk(err_bit[5:3] == t1, "R5 R7 chunk1 bit", 32'(err_bit[5:3]), 32'(t1));
      @(negedge clk);
      chk(done == 1'b0, "R2 done single cycle", 32'(done), 0);
   endtask

   task automatic wait_fix_done(output int n);
      n = 2;
      while (!fix_done && n < 40) begin
         @(negedge clk);
         n++;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      int n;
      logic [23:0] s;
      logic [10:0] p, p2;
      for (int i = 0; i < 512; i++) mem[i] = 8'(i * 29 + 5);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(done == 0 && fix_done == 0 && mem_rd == 0 && mem_wr == 0, "R1 strobes idle",
          {28'd0, done, fix_done, mem_rd, mem_wr}, 0);
      chk(status == 0 && chunk_status == 0, "R1 status zero", 32'(chunk_status), 0);
      chk(err_offset == 0 && err_bit == 0, "R1 location zero", 32'(err_offset), 0);
      rst_n = 1'b1;

      // R3 clean cases
      run(24'h000000, 24'h123456, 24'h0, 24'h0, 1'b0, 1'b0);
      run(24'h654321, 24'h000000, 24'h0, 24'h0, 1'b0, 1'b0);
      run(24'hABCDEF, 24'hABCDEF, 24'h112233, 24'h112233, 1'b1, 1'b0);
      chk(fix_done == 1'b1, "R10 fix_done with nothing to repair", 32'(fix_done), 1);

      // R4 single-bit syndromes
      for (int b = 0; b < 24; b++) begin
         run(24'hA5C3F1, 24'hA5C3F1 ^ (24'd1 << b), 24'h0, 24'h0, 1'b0, 1'b0);
         chk(mem_rd == 0, "R4 no memory access", 32'(mem_rd), 0);
      end

      // R6 two-bit syndromes and a non-complementary 11-bit one
      for (int a = 0; a < 24; a++)
         for (int b = a + 1; b < 24; b++)
            run(24'h3C5A96, 24'h3C5A96 ^ (24'd1 << a) ^ (24'd1 << b), 24'h0, 24'h0, 1'b0, 1'b0);
      run(24'h800001, 24'h800001 ^ 24'hC001FF, 24'h0, 24'h0, 1'b0, 1'b0);

      // R5 R7 sweep of every byte and bit, alternating page mode
      for (int i = 0; i < 2048; i++) begin
         p  = 11'(i);
         p2 = 11'(i * 37 + 11);
         s  = {1'b1, 23'(i * 40503)};
         run(s, s ^ fix_syn(p), 24'h9E3779, 24'h9E3779 ^ ((i[0]) ? fix_syn(p2) : 24'h000003),
             i[0], 1'b0);
      end

      // R8 worst-of-two combinations
      run(24'h111111, 24'h111110, 24'h222222, 24'h222225, 1'b1, 1'b0);
      run(24'h333333, 24'h333330, 24'h444444, 24'h444444, 1'b1, 1'b0);
      run(24'h800000, 24'h800000 ^ fix_syn(11'h055), 24'h555555, 24'h555554, 1'b1, 1'b0);

      // R9 R10 repair of both chunks, with an ignored start during repair
      run(24'h800000, 24'h800000 ^ fix_syn({8'h12, 3'd3}),
          24'h800100, 24'h800100 ^ fix_syn({8'h80, 3'd6}), 1'b1, 1'b1);
      chk(mem_rd == 1 && mem_addr == 9'h012, "R9 first read at chunk0 offset",
          32'(mem_addr), 32'h12);
      stored_codes = 48'h000001_000001;
      calc_codes   = 48'h000003_000003;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done == 0, "R10 start ignored while repairing", 32'(done), 0);
      chk(mem_wr == 1 && mem_wdata == (8'(18 * 29 + 5) ^ 8'h08), "R9 first write data",
          32'(mem_wdata), 32'(8'(18 * 29 + 5) ^ 8'h08));
      @(negedge clk);
      chk(mem_rd == 1 && mem_addr == 9'h180, "R9 second read at chunk1 offset",
          32'(mem_addr), 32'h180);
      n = 4;
      while (!fix_done && n < 40) begin @(negedge clk); n++; end
      chk(n == 6, "R10 fix_done after two repairs", n, 6);
      chk(mem[9'h012] == (8'(18 * 29 + 5) ^ 8'h08), "R9 chunk0 byte patched",
          32'(mem[9'h012]), 32'(8'(18 * 29 + 5) ^ 8'h08));
      chk(mem[9'h180] == (8'(384 * 29 + 5) ^ 8'h40), "R9 chunk1 byte patched",
          32'(mem[9'h180]), 32'(8'(384 * 29 + 5) ^ 8'h40));
      chk(status == 1 && err_offset[8:0] == 9'h012, "R10 outputs kept after ignored start",
          32'(err_offset[8:0]), 32'h12);

      // R9 R10 chunk0 bad, only chunk1 repaired
      run(24'h700000, 24'h700003, 24'h800000, 24'h800000 ^ fix_syn({8'h01, 3'd0}), 1'b1, 1'b1);
      wait_fix_done(n);
      chk(n == 4, "R10 fix_done after one repair", n, 4);
      chk(mem[9'h101] == (8'(257 * 29 + 5) ^ 8'h01), "R9 only correctable chunk patched",
          32'(mem[9'h101]), 32'(8'(257 * 29 + 5) ^ 8'h01));

      // R9 correctable but no fix request: memory untouched
      run(24'h800000, 24'h800000 ^ fix_syn({8'h40, 3'd2}), 24'h0, 24'h0, 1'b0, 1'b0);
      chk(fix_done == 1 && mem_rd == 0, "R9 no access without fix_req", 32'(mem_rd), 0);
      repeat (3) @(negedge clk);
      chk(mem[9'h040] == 8'(64 * 29 + 5), "R9 byte unchanged without fix_req",
          32'(mem[9'h040]), 32'(8'(64 * 29 + 5)));
      n = 0;
      for (int i = 0; i < 512; i++)
         if (i != 9'h012 && i != 9'h180 && i != 9'h101 && mem[i] != 8'(i * 29 + 5)) n++;
      chk(n == 0, "R9 no stray writes", n, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule